// File: doc/BRIEF.md
# GPIO Line Level Resolver

This block decides the logic level seen on each line of a small GPIO port. A line configured as an output carries the value held in the port's data register. A line configured as an input is not driven by the port. Its level then depends on the board's pull resistors: a pull-up gives 1 and a pull-down gives 0. A line with neither pull is truly floating, so it keeps the level last reported for it. The far end therefore sees no change on that line.

The pull configuration comes from one of two sources, chosen at build time. In the fixed variant, two mask parameters describe the board wiring. In the register variant, the port's pull-up and pull-down registers supply the masks. The block keeps the reported levels in a register, and it raises a one-cycle update strobe on every line whose level changed. During reset every line is treated as an input. On the first clock after reset the block announces every line that has a pull, so downstream logic is told those levels without waiting for software to touch the port.

Top module: `gpio_pull_resolve`

## Requirements
- R1: A line whose direction bit is 1 (output) reports its data-register bit one clock after the registers are presented.
- R2: An input line (direction bit 0) whose pull-up bit is set reports 1. In the register variant, a pull-up bit wins over a pull-down bit set on the same line.
- R3: An input line whose pull-down bit is set and whose pull-up bit is clear reports 0.
- R4: An input line with neither pull bit set keeps its previously reported level, and no update strobe is raised for it.
- R5: `line_upd` bit i is 1 for exactly the clock in which `line_level` bit i took a new value, and it is 0 for every unchanged line.
- R6: While reset is held, `line_level` equals the pull-up mask, as if all lines were inputs, and `line_upd` is 0.
- R7: On the first clock edge after reset is released, `line_upd` is 1 for every line that has a pull-up or a pull-down bit set.
- R8: With `PULL_SRC` set to the fixed variant, the masks come from `PULLUP_CFG` (default all ones) and `PULLDN_CFG` (default zero), and the register inputs are ignored. With the register variant, `pu_reg` and `pd_reg` supply the masks.
- R9: Elaboration fails if either mask parameter does not fit in `NLINES` bits, if the two masks overlap, or if `NLINES` lies outside 1 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_reg | input | NLINES | Port data register contents |
| dir_reg | input | NLINES | Direction register, 1 = output |
| pu_reg | input | NLINES | Pull-up register (register variant only) |
| pd_reg | input | NLINES | Pull-down register (register variant only) |
| line_level | output | NLINES | Reported level of each line |
| line_upd | output | NLINES | One-cycle strobe on each line whose level changed |

## Verification
The bench steers the floating lines between driven and undriven states. A design that let them fall to 0 or 1 instead of holding their level would report a wrong value and raise a spurious strobe. It checks the first cycle after reset for strobes on exactly the pulled lines. A design that missed the reset announcement, or that also flagged floating lines, would show the wrong mask. It runs the same input patterns against both variants. Fixed masks that read the registers by mistake, or a register variant that let the pull-down win a conflict, would give a different level on the affected line.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

   typedef enum logic {
      PULL_FIXED = 1'b0,
      PULL_REGS  = 1'b1
   } pull_src_e;

   // True when both masks fit in n bits and share no bit.
   function automatic bit pull_cfg_ok(int unsigned pu, int unsigned pd, int unsigned n);
      int unsigned lim;
      lim = 32'd1 << n;
      return (pu < lim) && (pd < lim) && ((pu & pd) == 0);
   endfunction

endpackage

// File: rtl/gpr_pull_src.sv
module gpr_pull_src #(
   parameter int unsigned          NLINES     = 8,
   parameter gpr_pkg::pull_src_e   PULL_SRC   = gpr_pkg::PULL_FIXED,
   parameter int unsigned          PULLUP_CFG = 32'hFF,
   parameter int unsigned          PULLDN_CFG = 32'h00
) (
   input  logic [NLINES-1:0] pu_reg,
   input  logic [NLINES-1:0] pd_reg,
   output logic [NLINES-1:0] pu_src,
   output logic [NLINES-1:0] pd_src
);

   localparam logic [NLINES-1:0] PU_MASK = PULLUP_CFG[NLINES-1:0];
   localparam logic [NLINES-1:0] PD_MASK = PULLDN_CFG[NLINES-1:0];

   generate
      if (PULL_SRC == gpr_pkg::PULL_REGS) begin : g_regs
         assign pu_src = pu_reg;
         assign pd_src = pd_reg;
      end else begin : g_fixed
         logic unused_regs;
         assign unused_regs = ^{pu_reg, pd_reg};
         assign pu_src = PU_MASK;
         assign pd_src = PD_MASK;
      end
   endgenerate

endmodule

// File: rtl/gpr_level_calc.sv
module gpr_level_calc #(
   parameter int unsigned NLINES = 8
) (
   input  logic [NLINES-1:0] data_reg,
   input  logic [NLINES-1:0] dir_reg,
   input  logic [NLINES-1:0] pu_src,
   input  logic [NLINES-1:0] pd_src,
   input  logic [NLINES-1:0] prev_level,
   output logic [NLINES-1:0] float_m,
   output logic [NLINES-1:0] pu_eff,
   output logic [NLINES-1:0] level_nxt
);

   logic [NLINES-1:0] is_input;

   always_comb begin
      is_input  = ~dir_reg;
      float_m   = ~(pu_src | pd_src) & is_input;
      pu_eff    = pu_src & is_input;
      level_nxt = (data_reg & dir_reg) | pu_eff | (prev_level & float_m);
   end

endmodule

// File: rtl/gpr_change_track.sv
module gpr_change_track #(
   parameter int unsigned NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] level_nxt,
   input  logic [NLINES-1:0] rst_level,
   input  logic [NLINES-1:0] rst_strobe,
   output logic [NLINES-1:0] level_q,
   output logic [NLINES-1:0] upd_q
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= rst_level;
         upd_q   <= '0;
         pend_q  <= 1'b1;
      end else begin
         level_q <= level_nxt;
         upd_q   <= (level_nxt ^ level_q) | (pend_q ? rst_strobe : '0);
         pend_q  <= 1'b0;
      end
   end

   // Outside the post-reset cycle a strobe marks exactly the changed lines.
   assert_upd_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |=> (upd_q == (level_q ^ $past(level_q))));

   // The first edge after reset announces every pulled line.
   assert_rst_announce_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> ((upd_q & $past(rst_strobe)) == $past(rst_strobe)));

endmodule

// File: rtl/gpio_pull_resolve.sv
module gpio_pull_resolve #(
   parameter int unsigned        NLINES     = 8,
   parameter gpr_pkg::pull_src_e PULL_SRC   = gpr_pkg::PULL_FIXED,
   parameter int unsigned        PULLUP_CFG = 32'hFF,
   parameter int unsigned        PULLDN_CFG = 32'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] data_reg,
   input  logic [NLINES-1:0] dir_reg,
   input  logic [NLINES-1:0] pu_reg,
   input  logic [NLINES-1:0] pd_reg,
   output logic [NLINES-1:0] line_level,
   output logic [NLINES-1:0] line_upd
);

   // R9: configuration checks at elaboration
   generate
      if (NLINES < 1 || NLINES > 31) begin : g_bad_width
         $error("gpio_pull_resolve: NLINES must be 1..31 (R9)");
      end else if (!gpr_pkg::pull_cfg_ok(PULLUP_CFG, PULLDN_CFG, NLINES)) begin : g_bad_cfg
         $error("gpio_pull_resolve: pull masks too wide or overlapping (R9)");
      end
   endgenerate

   logic [NLINES-1:0] pu_src;
   logic [NLINES-1:0] pd_src;
   logic [NLINES-1:0] float_m;
   logic [NLINES-1:0] pu_eff;
   logic [NLINES-1:0] level_nxt;
   logic [NLINES-1:0] level_q;
   logic [NLINES-1:0] pd_only;

   gpr_pull_src #(
      .NLINES     (NLINES),
      .PULL_SRC   (PULL_SRC),
      .PULLUP_CFG (PULLUP_CFG),
      .PULLDN_CFG (PULLDN_CFG)
   ) i_src (
      .pu_reg (pu_reg),
      .pd_reg (pd_reg),
      .pu_src (pu_src),
      .pd_src (pd_src)
   );

   gpr_level_calc #(.NLINES(NLINES)) i_calc (
      .data_reg   (data_reg),
      .dir_reg    (dir_reg),
      .pu_src     (pu_src),
      .pd_src     (pd_src),
      .prev_level (level_q),
      .float_m    (float_m),
      .pu_eff     (pu_eff),
      .level_nxt  (level_nxt)
   );

   gpr_change_track #(.NLINES(NLINES)) i_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_nxt  (level_nxt),
      .rst_level  (pu_src),
      .rst_strobe (pu_src | pd_src),
      .level_q    (level_q),
      .upd_q      (line_upd)
   );

   assign line_level = level_q;
   assign pd_only    = pd_src & ~pu_src & ~dir_reg;

   assert_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((level_q & $past(dir_reg)) == ($past(data_reg) & $past(dir_reg))));

   assert_pullup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((level_q & $past(pu_eff)) == $past(pu_eff)));

   assert_pulldown_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((level_q & $past(pd_only)) == '0));

   assert_float_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (float_m != '0) |=> ((level_q & $past(float_m)) == ($past(level_q) & $past(float_m))));

endmodule

// File: tb/test_gpio_pull_resolve.sv
module test_gpio_pull_resolve;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 5000;

   // Each entry: {dir, data, expected level, expected strobe} for the fixed variant
   // built with pull-ups 0xF0 and pull-downs 0x0C (lines 1:0 float as inputs).
   localparam logic [31:0] VEC [0:7] = '{
      32'hFF_A5_A5_55,
      32'hFF_A5_A5_00,
      32'h00_A5_F1_54,
      32'h03_02_F2_03,
      32'h00_00_F2_00,
      32'hF0_00_02_F0,
      32'h0C_FF_FE_FC,
      32'h00_FF_F2_0C
   };
   localparam string VEC_REQ [0:7] = '{"R1", "R1", "R2", "R1", "R4", "R3", "R2", "R4"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] b_data = 8'h00, b_dir = 8'h00;
   logic [7:0] b_pu = 8'h00, b_pd = 8'hFF;
   logic [7:0] e_data = 8'h00, e_dir = 8'h00;
   logic [7:0] e_pu = 8'h81, e_pd = 8'h18;
   logic [7:0] b_lvl, b_upd, e_lvl, e_upd;
   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_pull_resolve #(
      .NLINES(8), .PULL_SRC(gpr_pkg::PULL_FIXED), .PULLUP_CFG(32'hF0), .PULLDN_CFG(32'h0C)
   ) i_gpio_pull_resolve (
      .clk(clk), .rst_n(rst_n), .data_reg(b_data), .dir_reg(b_dir),
      .pu_reg(b_pu), .pd_reg(b_pd), .line_level(b_lvl), .line_upd(b_upd)
   );

   gpio_pull_resolve #(
      .NLINES(8), .PULL_SRC(gpr_pkg::PULL_REGS)
   ) i_gpio_pull_resolve_ext (
      .clk(clk), .rst_n(rst_n), .data_reg(e_data), .dir_reg(e_dir),
      .pu_reg(e_pu), .pd_reg(e_pd), .line_level(e_lvl), .line_upd(e_upd)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired before the run ended");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R6: during reset, levels equal the pull-up masks, no strobes
      chk("R6", "base level in reset", b_lvl, 8'hF0);
      chk("R6", "base strobe in reset", b_upd, 8'h00);
      chk("R6", "ext level in reset", e_lvl, 8'h81);
      chk("R6", "ext strobe in reset", e_upd, 8'h00);

      rst_n = 1'b1;
      step();
      // R7: pulled lines announced on the first edge after reset
      chk("R7", "base strobe after reset", b_upd, 8'hFC);
      chk("R7", "ext strobe after reset", e_upd, 8'h99);
      chk("R7", "base level after reset", b_lvl, 8'hF0);
      chk("R7", "ext level after reset", e_lvl, 8'h81);

      for (int i = 0; i < 8; i++) begin
         b_dir  = VEC[i][31:24];
         b_data = VEC[i][23:16];
         step();
         chk(VEC_REQ[i], $sformatf("base level vec %0d", i), b_lvl, VEC[i][15:8]);
         chk("R5", $sformatf("base strobe vec %0d", i), b_upd, VEC[i][7:0]);
      end

      // R8: fixed variant ignored the register inputs (pu 00 / pd FF) throughout
      chk("R8", "base level with registers ignored", b_lvl, 8'hF2);
      chk("R4", "ext idle hold strobe", e_upd, 8'h00);

      // Register variant
      e_pu = 8'h0F; e_pd = 8'hF0;
      step();
      chk("R8", "ext level from registers", e_lvl, 8'h0F);
      chk("R5", "ext strobe from registers", e_upd, 8'h8E);

      e_pu = 8'h00; e_pd = 8'h00;
      step();
      chk("R4", "ext all floating holds level", e_lvl, 8'h0F);
      chk("R4", "ext all floating no strobe", e_upd, 8'h00);

      e_dir = 8'hFF; e_data = 8'h3C;
      step();
      chk("R1", "ext driven level", e_lvl, 8'h3C);
      chk("R5", "ext driven strobe", e_upd, 8'h33);

      e_dir = 8'h00; e_pu = 8'h01; e_pd = 8'h01;
      step();
      chk("R2", "ext pull conflict resolves high", e_lvl, 8'h3D);
      chk("R5", "ext conflict strobe", e_upd, 8'h01);

      step();
      chk("R5", "ext steady state no strobe", e_upd, 8'h00);

      // R6/R7 again: reset in mid-run restores the pull-up masks
      rst_n = 1'b0;
      #1;
      chk("R6", "base level on reentering reset", b_lvl, 8'hF0);
      chk("R6", "ext level on reentering reset", e_lvl, 8'h01);
      chk("R6", "base strobe on reentering reset", b_upd, 8'h00);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule